// File: doc/BRIEF.md
# Conversion Result Queue with Level-Triggered DMA and Interrupt

This block sits between a conversion sequencer and a register read port. Each time a conversion finishes, the sequencer strobes in a 12-bit result together with an error flag. When storing is enabled, the result goes into a four-entry first-in first-out queue. A register read port pops results from the head of the queue.

Two settings are taken when a sample is stored. One narrows the result to eight bits. The other keeps the error flag in the read word. The block reports how many results are waiting, and whether the queue is full or empty. It also reports overflow and underflow, which stay set until cleared.

A DMA request and a raw interrupt both assert once the fill level reaches a programmable threshold. The interrupt line is built from the raw condition, an enable mask and a force bit.

Top module: `sample_queue`

## Requirements
- R1: While `cfg_store_en_i` is 0, a push strobe stores nothing and sets no overflow flag. The level stays unchanged.
- R2: `level_o` equals the number of stored results, from 0 to 4. `full_o` is 1 exactly when the level is 4. `empty_o` is 1 exactly when the level is 0.
- R3: Results leave in the order they arrived. The read word holds the value in bits 11:0 and holds zeros in bits 14:12.
- R4: A sample pushed while `cfg_pack_i` is 1 is stored as the input value shifted right by 4, so bits 11:8 read as zero. Changing `cfg_pack_i` later does not alter samples already stored.
- R5: `irq_raw_o` is 1 exactly when the level is greater than or equal to `cfg_thresh_i`.
- R6: `dma_req_o` is 1 exactly when `cfg_dma_en_i` is 1 and the level is greater than or equal to `cfg_thresh_i`.
- R7: A push while the queue is full and storing is enabled drops the new sample. The level stays at 4, the stored contents are unchanged, and `ovf_o` is set.
- R8: A pop while the queue is empty sets `unf_o` and leaves the level at 0. While the queue is empty, `pop_data_o` reads 0.
- R9: `ovf_o` and `unf_o` stay set until a 1 is strobed on their clear input. If a set event and a clear arrive in the same cycle, the flag stays set.
- R10: `irq_o` equals (`irq_raw_o` AND `irq_en_i`) OR `irq_force_i`.
- R11: After reset the queue is empty, with level 0 and both sticky flags at 0.
- R12: Bit 15 of the read word carries the sample's error flag only if `cfg_tag_err_i` was 1 when the sample was pushed. Otherwise bit 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Conversion-done strobe from the sequencer |
| push_data_i | input | 12 | Conversion result |
| push_err_i | input | 1 | Conversion error flag |
| pop_i | input | 1 | Read strobe that removes the head entry |
| pop_data_o | output | 16 | Formatted head entry, or 0 when the queue is empty |
| cfg_store_en_i | input | 1 | Store results in the queue |
| cfg_tag_err_i | input | 1 | Keep the error flag in bit 15 |
| cfg_pack_i | input | 1 | Shift results right by 4 to fit a byte |
| cfg_dma_en_i | input | 1 | Allow DMA requests |
| cfg_thresh_i | input | 4 | Fill-level threshold |
| ovf_clr_i | input | 1 | Write-one strobe that clears overflow |
| unf_clr_i | input | 1 | Write-one strobe that clears underflow |
| irq_en_i | input | 1 | Interrupt enable mask |
| irq_force_i | input | 1 | Interrupt force |
| level_o | output | 4 | Number of waiting results |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| ovf_o | output | 1 | Sticky overflow |
| unf_o | output | 1 | Sticky underflow |
| dma_req_o | output | 1 | DMA request |
| irq_raw_o | output | 1 | Raw threshold interrupt |
| irq_o | output | 1 | Masked and forced interrupt |

## Verification
The bench pushes a fifth sample into a full queue and then drains it. A design that overwrote the oldest entry, or that advanced the write pointer anyway, would return the wrong sequence of values.

It pops from an empty queue and expects the read data to stay at zero and the level to stay at zero. A design that lets the count wrap to 15 would break both.

It strobes a clear in the same cycle as a fresh overflow. A design that gave the clear priority would lose the event.

It changes the pack and tag settings after storing samples. A design that formats entries at read time, rather than at push time, would return the wrong words. Finally, it walks the level across the threshold with DMA enabled and disabled, and checks the interrupt mask and force terms separately.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int VAL_W  = 12;
  localparam int WORD_W = 16;
  localparam int LVL_W  = 4;
  localparam int PACK_SHIFT = 4;

  typedef struct packed {
    logic             err;
    logic [VAL_W-1:0] val;
  } sq_entry_t;

  // Build a stored entry from a raw sample using the settings active at push time
  function automatic sq_entry_t make_entry(input logic [VAL_W-1:0] v, input logic e,
                                           input logic pack, input logic tag);
    sq_entry_t r;
    r.val = pack ? (v >> PACK_SHIFT) : v;
    r.err = tag & e;
    return r;
  endfunction

  // Read word layout: error at bit 15, value in the low bits
  function automatic logic [WORD_W-1:0] fmt_word(input sq_entry_t x);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VAL_W-1:0] = x.val;
    w[WORD_W-1]  = x.err;
    return w;
  endfunction

  function automatic logic at_thresh(input logic [LVL_W-1:0] lvl, input logic [LVL_W-1:0] th);
    return lvl >= th;
  endfunction
endpackage

// File: rtl/sq_store.sv
module sq_store #(
  parameter int DEPTH = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  sq_pkg::sq_entry_t   wr_data,
  input  logic                rd_en,
  output sq_pkg::sq_entry_t   rd_data,
  output logic [CNT_W-1:0]    count
);
  sq_pkg::sq_entry_t mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[i] <= '0;
      else if (wr_en && wp == AW'(i))      mem[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= nxt(wp);
      if (rd_en) rp <= nxt(rp);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rp];
endmodule

// File: rtl/sq_sticky.sv
module sq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/sq_irq.sv
module sq_irq (
  input  logic [sq_pkg::LVL_W-1:0] level_i,
  input  logic [sq_pkg::LVL_W-1:0] thresh_i,
  input  logic                     dma_en_i,
  input  logic                     ie_i,
  input  logic                     force_i,
  output logic                     dma_req_o,
  output logic                     raw_o,
  output logic                     irq_o
);
  logic hit;
  assign hit       = sq_pkg::at_thresh(level_i, thresh_i);
  assign raw_o     = hit;
  assign dma_req_o = hit & dma_en_i;
  assign irq_o     = (hit & ie_i) | force_i;
endmodule

// File: rtl/sample_queue.sv
module sample_queue #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_i,
  input  logic [11:0] push_data_i,
  input  logic        push_err_i,
  input  logic        pop_i,
  output logic [15:0] pop_data_o,
  input  logic        cfg_store_en_i,
  input  logic        cfg_tag_err_i,
  input  logic        cfg_pack_i,
  input  logic        cfg_dma_en_i,
  input  logic [3:0]  cfg_thresh_i,
  input  logic        ovf_clr_i,
  input  logic        unf_clr_i,
  input  logic        irq_en_i,
  input  logic        irq_force_i,
  output logic [3:0]  level_o,
  output logic        full_o,
  output logic        empty_o,
  output logic        ovf_o,
  output logic        unf_o,
  output logic        dma_req_o,
  output logic        irq_raw_o,
  output logic        irq_o
);
  import sq_pkg::*;

  logic [CNT_W-1:0] count;
  sq_entry_t        in_entry, head;

  // Named internal events, brought out for the checker
  logic push_ok, ovf_evt, pop_ok, unf_evt;

  assign full_o   = (count == CNT_W'(DEPTH));
  assign empty_o  = (count == '0);
  assign push_ok  = push_i & cfg_store_en_i & ~full_o;
  assign ovf_evt  = push_i & cfg_store_en_i & full_o;
  assign pop_ok   = pop_i & ~empty_o;
  assign unf_evt  = pop_i & empty_o;
  assign in_entry = make_entry(push_data_i, push_err_i, cfg_pack_i, cfg_tag_err_i);

  sq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_ok), .wr_data(in_entry),
    .rd_en(pop_ok), .rd_data(head), .count(count)
  );

  assign level_o    = LVL_W'(count);
  assign pop_data_o = empty_o ? '0 : fmt_word(head);

  sq_sticky u_ovf (.clk(clk), .rst_n(rst_n), .set_i(ovf_evt), .clr_i(ovf_clr_i), .q_o(ovf_o));
  sq_sticky u_unf (.clk(clk), .rst_n(rst_n), .set_i(unf_evt), .clr_i(unf_clr_i), .q_o(unf_o));

  sq_irq u_irq (
    .level_i(level_o), .thresh_i(cfg_thresh_i), .dma_en_i(cfg_dma_en_i),
    .ie_i(irq_en_i), .force_i(irq_force_i),
    .dma_req_o(dma_req_o), .raw_o(irq_raw_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(parameter int DEPTH = 4) (
  input logic        clk,
  input logic        rst_n,
  input logic        push_i,
  input logic        pop_i,
  input logic        store_en,
  input logic        dma_en,
  input logic        irq_force,
  input logic        ovf_clr,
  input logic        unf_clr,
  input logic [3:0]  level,
  input logic        full,
  input logic        empty,
  input logic [15:0] pop_data,
  input logic        ovf,
  input logic        unf,
  input logic        dma_req,
  input logic        irq,
  input logic        ovf_evt,
  input logic        unf_evt
);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 4'(DEPTH));
  p_full_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> level == 4'(DEPTH));
  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!store_en && !pop_i) |=> $stable(level) && !$rose(ovf));
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && store_en && full && !pop_i) |=> full && ovf);
  p_unf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty) |=> unf && level == 4'd0);
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> pop_data == 16'h0);
  p_hold_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  p_hold_unf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && !unf_clr) |=> unf);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf);
  p_set_wins_unf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> unf);
  p_dma_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);
  p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_force |-> irq);
endmodule

bind sample_queue sq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
  .store_en(cfg_store_en_i), .dma_en(cfg_dma_en_i), .irq_force(irq_force_i),
  .ovf_clr(ovf_clr_i), .unf_clr(unf_clr_i), .level(level_o), .full(full_o),
  .empty(empty_o), .pop_data(pop_data_o), .ovf(ovf_o), .unf(unf_o),
  .dma_req(dma_req_o), .irq(irq_o), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
);

// File: tb/sim_sample_queue.sv
module sim_sample_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_i = 0, push_err_i = 0, pop_i = 0;
  logic [11:0] push_data_i = '0;
  logic cfg_store_en_i = 0, cfg_tag_err_i = 0, cfg_pack_i = 0, cfg_dma_en_i = 0;
  logic [3:0] cfg_thresh_i = 4'd1;
  logic ovf_clr_i = 0, unf_clr_i = 0, irq_en_i = 0, irq_force_i = 0;
  logic [15:0] pop_data_o;
  logic [3:0] level_o;
  logic full_o, empty_o, ovf_o, unf_o, dma_req_o, irq_raw_o, irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sample_queue u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Every step: drive at negedge, state settles at posedge, sample at the following negedge
  task automatic push(input logic [11:0] d, input logic e);
    @(negedge clk); push_i = 1; push_data_i = d; push_err_i = e;
    @(negedge clk); push_i = 0;
  endtask

  task automatic pop_expect(input string req, input logic [15:0] exp);
    chk(req, 32'(pop_data_o), 32'(exp));
    pop_i = 1;
    @(negedge clk); pop_i = 0;
  endtask

  task automatic t_reset;
    chk("R11 level", 32'(level_o), 0);
    chk("R11 empty", 32'(empty_o), 1);
    chk("R11 full", 32'(full_o), 0);
    chk("R11 ovf", 32'(ovf_o), 0);
    chk("R11 unf", 32'(unf_o), 0);
  endtask

  task automatic t_gate;
    cfg_store_en_i = 0;
    push(12'h123, 0);
    chk("R1 level", 32'(level_o), 0);
    chk("R1 ovf", 32'(ovf_o), 0);
    cfg_store_en_i = 1;
  endtask

  task automatic t_order;
    cfg_tag_err_i = 1;
    push(12'h111, 1);
    push(12'h222, 0);
    push(12'hFFF, 1);
    chk("R2 level3", 32'(level_o), 3);
    chk("R2 notempty", 32'(empty_o), 0);
    cfg_tag_err_i = 0;
    pop_expect("R3 first R12", 16'h8111);
    pop_expect("R3 second", 16'h0222);
    pop_expect("R3 third R12", 16'h8FFF);
    push(12'h456, 1);
    chk("R12 untagged", 32'(pop_data_o[15]), 0);
    pop_expect("R12 word", 16'h0456);
    chk("R2 empty", 32'(empty_o), 1);
  endtask

  task automatic t_pack;
    cfg_pack_i = 1;
    push(12'hABC, 0);
    cfg_pack_i = 0;
    push(12'hABC, 0);
    cfg_pack_i = 1;
    pop_expect("R4 packed", 16'h00AB);
    pop_expect("R4 unpacked kept", 16'h0ABC);
    cfg_pack_i = 0;
  endtask

  task automatic t_thresh;
    cfg_thresh_i = 4'd3; cfg_dma_en_i = 1;
    push(12'h001, 0); push(12'h002, 0);
    chk("R5 below raw", 32'(irq_raw_o), 0);
    chk("R6 below dma", 32'(dma_req_o), 0);
    push(12'h003, 0);
    chk("R5 at raw", 32'(irq_raw_o), 1);
    chk("R6 at dma", 32'(dma_req_o), 1);
    @(negedge clk); cfg_dma_en_i = 0; #1;
    chk("R6 disabled", 32'(dma_req_o), 0);
    chk("R5 raw stays", 32'(irq_raw_o), 1);
    for (int i = 0; i < 3; i++) pop_expect("R3 drain", 16'(i + 1));
    cfg_thresh_i = 4'd1;
  endtask

  task automatic t_ovf;
    for (int i = 0; i < 4; i++) push(12'h10 + 12'(i), 0);
    chk("R2 full", 32'(full_o), 1);
    chk("R2 level4", 32'(level_o), 4);
    push(12'hEEE, 0);
    chk("R7 ovf set", 32'(ovf_o), 1);
    chk("R7 level kept", 32'(level_o), 4);
    @(negedge clk); ovf_clr_i = 1; push_i = 1; push_data_i = 12'hDDD;
    @(negedge clk); ovf_clr_i = 0; push_i = 0;
    chk("R9 set wins", 32'(ovf_o), 1);
    @(negedge clk); chk("R9 sticky", 32'(ovf_o), 1);
    ovf_clr_i = 1;
    @(negedge clk); ovf_clr_i = 0;
    chk("R9 cleared", 32'(ovf_o), 0);
    for (int i = 0; i < 4; i++) pop_expect("R7 contents", 16'h10 + 16'(i));
  endtask

  task automatic t_unf;
    chk("R8 empty data", 32'(pop_data_o), 0);
    pop_expect("R8 pop empty", 16'h0);
    chk("R8 unf set", 32'(unf_o), 1);
    chk("R8 level", 32'(level_o), 0);
    @(negedge clk); chk("R9 unf sticky", 32'(unf_o), 1);
    unf_clr_i = 1;
    @(negedge clk); unf_clr_i = 0;
    chk("R9 unf cleared", 32'(unf_o), 0);
  endtask

  task automatic t_irq;
    push(12'h5, 0);
    irq_en_i = 0; irq_force_i = 0; #1;
    chk("R10 masked", 32'(irq_o), 0);
    irq_en_i = 1; #1;
    chk("R10 enabled", 32'(irq_o), 1);
    pop_expect("R3 irq drain", 16'h5);
    chk("R10 raw low", 32'(irq_o), 0);
    irq_force_i = 1; #1;
    chk("R10 force", 32'(irq_o), 1);
    irq_force_i = 0; irq_en_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_gate();
    t_order();
    t_pack();
    t_thresh();
    t_ovf();
    t_unf();
    t_irq();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule